// File: doc/BRIEF.md
# Base-Limit Address Relocation Unit

This block sits between the load/store stage of a processor and the RAM port. Every memory request arrives with a program address, a read/write flag, write data and the current privilege mode. In user mode the address is checked against a per-process limit and then offset by a per-process base. Only accesses that pass this check reach RAM. In kernel mode the address goes to RAM as it is, with no check.

The base and limit registers belong to whichever process is running. The operating system reloads them on every process switch, and it may do so only from kernel mode. A failed bounds check raises a protection fault toward the trap logic. A register write attempted from user mode raises a privilege fault and changes nothing. All RAM-side outputs and both fault flags are registered, so each appears one clock after the request that caused it.

Top module: `bound_reloc`

## Requirements
- R1: After reset, base and limit are zero, and memValid, memRw, physAddr, memWrData, protFault and privFault are all zero.
- R2: A user-mode request (kernelMode=0, memReq=1) whose progAddr is strictly below limit, and whose base+progAddr fits in 32 bits, gives memValid=1 and physAddr=base+progAddr on the next cycle.
- R3: A user-mode request with progAddr equal to or above limit gives protFault=1, memValid=0 and physAddr=0 on the next cycle.
- R4: A user-mode request whose base+progAddr carries out of 32 bits is a protection fault, handled the same way as R3.
- R5: A kernel-mode request (kernelMode=1) gives memValid=1 and physAddr=progAddr on the next cycle, whatever the base and limit values are.
- R6: A kernel-mode register write (regWrEn=1) loads regWrData into base when regSel=0 and into limit when regSel=1. The new value is used from the following cycle onward.
- R7: A register write attempted in user mode leaves base and limit unchanged and gives privFault=1 on the next cycle.
- R8: memRw and memWrData carry the request's memWrite and wrData only when memValid=1. Otherwise both are zero.
- R9: A cycle with memReq=0 gives memValid=0 and protFault=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| kernelMode | input | 1 | 1 = kernel mode, 0 = user mode |
| regWrEn | input | 1 | Request to load base or limit |
| regSel | input | 1 | 0 selects base, 1 selects limit |
| regWrData | input | 32 | Value to load |
| memReq | input | 1 | Load/store request |
| memWrite | input | 1 | 1 = store, 0 = load |
| progAddr | input | 32 | Program (logical) address |
| wrData | input | 32 | Store data |
| memValid | output | 1 | Access issued to RAM |
| memRw | output | 1 | RAM read/write line, 1 = write |
| physAddr | output | 32 | Physical address to RAM |
| memWrData | output | 32 | Write data to RAM |
| protFault | output | 1 | Bounds or overflow violation |
| privFault | output | 1 | User-mode register write attempt |

## Verification
The assertions assume that kernelMode, memReq and the register-write inputs stay constant from one clock edge to the next, and that they hold zero while reset is active. Under that assumption, every $past value taken just after reset refers to an idle cycle. The bench changes inputs only on falling edges, and it drives all of them low throughout reset. Random addresses are chosen relative to the live limit, so both sides of the bound and the exact boundary value are hit often. Directed cases cover a base near the top of the address space, so the carry-out path is exercised.

// File: rtl/bound_reloc_pkg.sv
package bound_reloc_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic loadBase;
    logic loadLimit;
    logic passAddr;
    logic relocAddr;
    logic setProt;
    logic setPriv;
  } ctrlStrobes_t;
endpackage

// File: rtl/bound_reloc_ctrl.sv
module bound_reloc_ctrl
  import bound_reloc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         kernelMode,
  input  logic         regWrEn,
  input  logic         regSel,
  input  logic         memReq,
  input  logic         inBounds,
  input  logic         sumCarry,
  output ctrlStrobes_t strobes,
  output logic         protFault,
  output logic         privFault
);
  logic userOk;

  assign userOk = inBounds && !sumCarry;

  always_comb begin
    strobes           = '0;
    strobes.loadBase  = regWrEn && kernelMode && !regSel;
    strobes.loadLimit = regWrEn && kernelMode && regSel;
    strobes.setPriv   = regWrEn && !kernelMode;
    if (memReq) begin
      if (kernelMode)  strobes.passAddr  = 1'b1;
      else if (userOk) strobes.relocAddr = 1'b1;
      else             strobes.setProt   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protFault <= 1'b0;
      privFault <= 1'b0;
    end else begin
      protFault <= strobes.setProt;
      privFault <= strobes.setPriv;
    end
  end
endmodule

// File: rtl/bound_reloc_dp.sv
module bound_reloc_dp
  import bound_reloc_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobes_t  strobes,
  input  logic [AW-1:0] regWrData,
  input  logic          memWrite,
  input  logic [AW-1:0] progAddr,
  input  logic [DW-1:0] wrData,
  output logic          inBounds,
  output logic          sumCarry,
  output logic          memValid,
  output logic          memRw,
  output logic [AW-1:0] physAddr,
  output logic [DW-1:0] memWrData
);
  logic [AW-1:0] baseQ;
  logic [AW-1:0] limitQ;
  logic [AW-1:0] relocSum;
  logic [AW-1:0] nextAddr;
  logic          issue;

  assign inBounds             = progAddr < limitQ;
  assign {sumCarry, relocSum} = {1'b0, baseQ} + {1'b0, progAddr};
  assign issue                = strobes.passAddr || strobes.relocAddr;
  assign nextAddr             = strobes.relocAddr ? relocSum :
                                strobes.passAddr  ? progAddr : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      limitQ <= '0;
    end else begin
      if (strobes.loadBase)  baseQ  <= regWrData;
      if (strobes.loadLimit) limitQ <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memValid  <= 1'b0;
      memRw     <= 1'b0;
      physAddr  <= '0;
      memWrData <= '0;
    end else begin
      memValid  <= issue;
      memRw     <= issue && memWrite;
      physAddr  <= nextAddr;
      memWrData <= issue ? wrData : '0;
    end
  end
endmodule

// File: rtl/bound_reloc.sv
module bound_reloc
  import bound_reloc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              kernelMode,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic              memReq,
  input  logic              memWrite,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              memValid,
  output logic              memRw,
  output logic [ADDR_W-1:0] physAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              protFault,
  output logic              privFault
);
  ctrlStrobes_t strobes;
  logic         inBounds;
  logic         sumCarry;

  bound_reloc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .kernelMode(kernelMode), .regWrEn(regWrEn),
    .regSel(regSel), .memReq(memReq), .inBounds(inBounds),
    .sumCarry(sumCarry), .strobes(strobes), .protFault(protFault),
    .privFault(privFault)
  );

  bound_reloc_dp #(.AW(ADDR_W), .DW(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrData(regWrData),
    .memWrite(memWrite), .progAddr(progAddr), .wrData(wrData),
    .inBounds(inBounds), .sumCarry(sumCarry), .memValid(memValid),
    .memRw(memRw), .physAddr(physAddr), .memWrData(memWrData)
  );
endmodule

// File: rtl/bound_reloc_chk.sv
module bound_reloc_chk
  import bound_reloc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              kernelMode,
  input logic              regWrEn,
  input logic              memReq,
  input logic [ADDR_W-1:0] progAddr,
  input logic              memValid,
  input logic              memRw,
  input logic [ADDR_W-1:0] physAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic              protFault,
  input logic              privFault
);
  assert_prot_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    protFault |-> (!memValid && physAddr == '0));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !kernelMode) |=> (!memValid || physAddr >= $past(progAddr)));

  assert_kernel_pass_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && kernelMode) |=> (memValid && physAddr == $past(progAddr)));

  assert_user_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !kernelMode) |=> privFault);

  assert_gate_rw_R8: assert property (@(posedge clk) disable iff (!rstN)
    !memValid |-> (!memRw && memWrData == '0));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !memReq |=> (!memValid && !protFault));
endmodule

bind bound_reloc bound_reloc_chk u_chk (
  .clk(clk), .rstN(rstN), .kernelMode(kernelMode), .regWrEn(regWrEn),
  .memReq(memReq), .progAddr(progAddr), .memValid(memValid), .memRw(memRw),
  .physAddr(physAddr), .memWrData(memWrData), .protFault(protFault),
  .privFault(privFault)
);

// File: tb/bound_reloc_bench.sv
`timescale 1ns/1ps
module bound_reloc_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        kernelMode, regWrEn, regSel, memReq, memWrite;
  logic [31:0] regWrData, progAddr, wrData;
  logic        memValid, memRw, protFault, privFault;
  logic [31:0] physAddr, memWrData;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mBase = 0;
  logic [31:0] mLimit = 0;

  always #2.5 clk = ~clk;

  bound_reloc u_bound_reloc (
    .clk(clk), .rstN(rstN), .kernelMode(kernelMode), .regWrEn(regWrEn),
    .regSel(regSel), .regWrData(regWrData), .memReq(memReq),
    .memWrite(memWrite), .progAddr(progAddr), .wrData(wrData),
    .memValid(memValid), .memRw(memRw), .physAddr(physAddr),
    .memWrData(memWrData), .protFault(protFault), .privFault(privFault)
  );

  function automatic logic userOk(input logic [31:0] a);
    logic [32:0] s;
    s = {1'b0, mBase} + {1'b0, a};
    return (a < mLimit) && !s[32];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, sample after the next posedge, compare to the model
  task automatic step(input logic km, input logic we, input logic sel, input logic [31:0] wd,
                      input logic rq, input logic wr, input logic [31:0] a,
                      input logic [31:0] d, input string req);
    logic ok, pass;
    logic [31:0] eAddr;
    @(negedge clk);
    kernelMode = km; regWrEn = we; regSel = sel; regWrData = wd;
    memReq = rq; memWrite = wr; progAddr = a; wrData = d;
    pass  = rq && (km || userOk(a));
    eAddr = !pass ? 32'h0 : (km ? a : mBase + a);
    @(posedge clk); #1;
    check({req, " memValid"}, {31'b0, memValid}, {31'b0, pass});
    check({req, " physAddr"}, physAddr, eAddr);
    check({req, " R8 memRw"}, {31'b0, memRw}, {31'b0, pass && wr});
    check({req, " R8 memWrData"}, memWrData, pass ? d : 32'h0);
    ok = rq && !km && !userOk(a);
    check({req, " protFault"}, {31'b0, protFault}, {31'b0, ok});
    check({req, " R7 privFault"}, {31'b0, privFault}, {31'b0, we && !km});
    if (we && km) begin
      if (sel) mLimit = wd; else mBase = wd;
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));
    rstN = 0; kernelMode = 0; regWrEn = 0; regSel = 0; regWrData = 0;
    memReq = 0; memWrite = 0; progAddr = 0; wrData = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 memValid", {31'b0, memValid}, 32'h0);
    check("R1 physAddr", physAddr, 32'h0);
    check("R1 faults", {30'b0, protFault, privFault}, 32'h0);
    @(negedge clk); rstN = 1;

    // R1: limit is zero after reset, so any user access faults
    step(0, 0, 0, 0, 1, 0, 32'h0, 32'h11, "R1 zero-limit");
    // R6: kernel loads base and limit
    step(1, 1, 0, 32'h0000_1000, 0, 0, 0, 0, "R6 base");
    step(1, 1, 1, 32'h0000_0100, 0, 0, 0, 0, "R6 limit");
    // R2: in bounds and the top valid address
    step(0, 0, 0, 0, 1, 1, 32'h0000_0010, 32'hAA, "R2 inside");
    step(0, 0, 0, 0, 1, 0, 32'h0000_00FF, 32'hBB, "R2 last");
    // R3: exactly at the limit and above it
    step(0, 0, 0, 0, 1, 1, 32'h0000_0100, 32'hCC, "R3 at-limit");
    step(0, 0, 0, 0, 1, 0, 32'h8000_0000, 32'hCC, "R3 above");
    // R5: kernel pass-through ignores the limit
    step(1, 0, 0, 0, 1, 1, 32'hFFFF_FFF0, 32'hDD, "R5 kernel");
    // R7: user write is ignored; the base is probed afterwards
    step(0, 1, 0, 32'h0000_5000, 0, 0, 0, 0, "R7 user-base");
    step(0, 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R7 user-limit");
    step(0, 0, 0, 0, 1, 0, 32'h0000_0020, 0, "R7 probe");
    // R9: idle cycle
    step(0, 0, 0, 0, 0, 1, 32'h0000_0020, 32'hEE, "R9 idle");
    // R4: base near the top of the address space with a large limit
    step(1, 1, 0, 32'hFFFF_FF00, 0, 0, 0, 0, "R4 base");
    step(1, 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R4 limit");
    step(0, 0, 0, 0, 1, 1, 32'h0000_00FF, 32'h1, "R4 no-carry");
    step(0, 0, 0, 0, 1, 1, 32'h0000_0100, 32'h2, "R4 carry");
    // R6: a write and a request in the same cycle use the old value
    step(1, 1, 0, 32'h0000_0000, 1, 0, 32'h0000_0123, 0, "R6 same-cycle");

    for (int i = 0; i < 400; i++) begin
      logic km, we, sel, rq, wr;
      logic [31:0] wd, a;
      km = ($urandom % 4) == 0;
      we = ($urandom % 6) == 0;
      sel = $urandom % 2;
      wd = sel ? ($urandom % 32'h2000) : (($urandom % 8 == 0) ? 32'hFFFF_F000 : $urandom % 32'h10000);
      rq = ($urandom % 5) != 0;
      wr = $urandom % 2;
      case ($urandom % 4)
        0: a = mLimit;
        1: a = (mLimit == 0) ? 0 : mLimit - 1;
        default: a = $urandom % (mLimit * 2 + 2);
      endcase
      step(km, we, sel, wd, rq, wr, a, $urandom, "R2 R3 R4 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule